// File: doc/BRIEF.md
# Parallel CRC Word Step

This block advances a cyclic redundancy check by one whole data word per clock. Each next-state bit is the parity of two selections: some bits of the current CRC state and some bits of the incoming word. The selection rows are fixed at elaboration. A constant function derives them by running the serial shift-register update symbolically, once for each data bit, against the chosen polynomial and word width. No lookup table exists at run time.

The word is consumed in a defined serial order. When the width is a whole number of bytes, the least significant byte goes first. A reflection option reverses the bit order inside each byte, and only inside each byte, so the byte order of the word stays the same. A second option reverses the bit order of the CRC as it leaves the block.

A small registered wrapper holds the running state. It loads the seed on clear and advances the state on valid, so a stream of words can be chained one per cycle. Final XOR handling is left to the user.

Top module: `crcx_step`

## Requirements
- R1: When valid_i is high and clear_i is low at a rising edge, the state after that edge equals the state after DW single-bit serial steps taken from the old state. One serial step computes feedback as the state MSB (bit CW-1) XOR the input bit, shifts the state left by one, and XORs POLY into the state if the feedback is 1. POLY excludes the implicit top term.
- R2: With input reflection off and DW a multiple of 8, bytes are consumed from the least significant byte (bits 7:0) upward, and each byte is taken bit 7 first. When DW is not a multiple of 8, the word is taken from bit DW-1 down to bit 0.
- R3: With input reflection on, each byte is taken bit 0 first, and the byte order is still least significant byte first.
- R4: With output reflection on, crc_o bit i equals state bit CW-1-i. With it off, crc_o equals the state. crc_o is never unknown after reset.
- R5: While rst_ni is low, the state is set to SEED, so crc_o shows SEED (reflected if output reflection is on) in the first cycle after reset is released.
- R6: clear_i high at a rising edge loads SEED, and it takes priority over valid_i.
- R7: With clear_i and valid_i both low, the state and crc_o hold, whatever data_i carries.
- R8: With CW=32, POLY=32'h04C11DB7, SEED all ones, both reflections on, DW=8, and the nine ASCII bytes "123456789" given in order, crc_o ends at 32'h340BC6D9. This is the usual check value before the final inversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Active-low synchronous reset, loads SEED |
| clear_i | input | 1 | Reload SEED on the next edge |
| valid_i | input | 1 | Fold data_i into the state on the next edge |
| data_i | input | DW | Data word |
| crc_o | output | CW | Running CRC, optionally bit-reversed |

## Verification
Three configurations are driven: a 16-bit CRC over 16-bit words, a 32-bit byte-wide CRC with both reflections on, and a 5-bit CRC over an 11-bit word, which is not whole bytes. Words with a single bit set at either end of a byte separate the byte-order, bit-order and reflection choices, because a wrong order feeds that bit in at a different serial step. All-zero and all-one words and the ASCII pair "12" exercise the dense parity paths. Idle cycles with changing data, clear combined with valid, and the standard nine-character check string cover holding, clear priority and the end-to-end result.

// File: rtl/crcx_pkg.sv
package crcx_pkg;

    // Position in the data word of the bit consumed at serial step k.
    function automatic int serial_index(int k, int dw, bit refin);
        int pos;
        if (dw % 8 == 0) begin
            pos = 8 * (k / 8) + (refin ? (k % 8) : (7 - (k % 8)));
        end else begin
            pos = dw - 1 - k;
        end
        return pos;
    endfunction

endpackage

// File: rtl/crcx_lane_map.sv
module crcx_lane_map #(
    parameter int DW    = 16,
    parameter bit REFIN = 1'b0
) (
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] ser_o
);
    // ser_o[k] is the bit fed at serial step k
    for (genvar k = 0; k < DW; k++) begin : g_lane
        localparam int SRC = crcx_pkg::serial_index(k, DW, REFIN);
        assign ser_o[k] = data_i[SRC];
    end
endmodule

// File: rtl/crcx_xor_matrix.sv
module crcx_xor_matrix #(
    parameter int            CW   = 16,
    parameter int            DW   = 16,
    parameter logic [CW-1:0] POLY = 16'h1021
) (
    input  logic [CW-1:0] state_i,
    input  logic [DW-1:0] ser_i,
    output logic [CW-1:0] next_o
);
    localparam int TW = CW + DW;
    typedef logic [CW-1:0][TW-1:0] mat_t;

    // Symbolic unroll: row i lists which of {ser, state} bits feed bit i.
    function automatic mat_t build_rows();
        mat_t m;
        logic [TW-1:0] fb;
        for (int i = 0; i < CW; i++) begin
            m[i]    = '0;
            m[i][i] = 1'b1;
        end
        for (int k = 0; k < DW; k++) begin
            fb          = m[CW-1];
            fb[CW + k]  = ~fb[CW + k];
            for (int i = CW - 1; i > 0; i--) begin
                m[i] = m[i-1] ^ (POLY[i] ? fb : '0);
            end
            m[0] = POLY[0] ? fb : '0;
        end
        return m;
    endfunction

    localparam mat_t ROWS = build_rows();

    logic [TW-1:0] operand;
    assign operand = {ser_i, state_i};

    for (genvar i = 0; i < CW; i++) begin : g_row
        localparam logic [CW-1:0] ST_MASK = ROWS[i][CW-1:0];
        localparam logic [DW-1:0] DT_MASK = ROWS[i][TW-1:CW];
        assign next_o[i] = (^(state_i & ST_MASK)) ^ (^(ser_i & DT_MASK));
    end

    logic unused_operand;
    assign unused_operand = ^operand;
endmodule

// File: rtl/crcx_reflect.sv
module crcx_reflect #(
    parameter int W  = 16,
    parameter bit EN = 1'b0
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    if (EN) begin : g_rev
        for (genvar i = 0; i < W; i++) begin : g_bit
            assign out_o[i] = in_i[W-1-i];
        end
    end else begin : g_pass
        assign out_o = in_i;
    end
endmodule

// File: rtl/crcx_step.sv
module crcx_step #(
    parameter int            CW     = 16,
    parameter int            DW     = 16,
    parameter logic [CW-1:0] POLY   = 16'h1021,
    parameter logic [CW-1:0] SEED   = '1,
    parameter bit            REFIN  = 1'b0,
    parameter bit            REFOUT = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clear_i,
    input  logic          valid_i,
    input  logic [DW-1:0] data_i,
    output logic [CW-1:0] crc_o
);
    if (REFIN && (DW % 8 != 0)) begin : g_bad_cfg
        $error("crcx_step: byte reflection needs DW to be a multiple of 8");
    end

    typedef struct packed {
        logic [CW-1:0] crc;
    } regs_t;

    regs_t         r_d, r_q;
    logic [DW-1:0] ser;
    logic [CW-1:0] step_nxt;

    crcx_lane_map #(.DW(DW), .REFIN(REFIN)) u_lane (
        .data_i (data_i),
        .ser_o  (ser)
    );

    crcx_xor_matrix #(.CW(CW), .DW(DW), .POLY(POLY)) u_matrix (
        .state_i (r_q.crc),
        .ser_i   (ser),
        .next_o  (step_nxt)
    );

    crcx_reflect #(.W(CW), .EN(REFOUT)) u_outrev (
        .in_i  (r_q.crc),
        .out_o (crc_o)
    );

    always_comb begin
        r_d = r_q;
        if (clear_i) begin
            r_d.crc = SEED;
        end else if (valid_i) begin
            r_d.crc = step_nxt;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q.crc <= SEED;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/crcx_step_chk.sv
module crcx_step_chk #(
    parameter int            CW   = 16,
    parameter logic [CW-1:0] SEED = '1
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          clear_i,
    input logic          valid_i,
    input logic [CW-1:0] state_q,
    input logic [CW-1:0] crc_o
);
    // R6
    clear_loads_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (state_q == SEED));

    // R7
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clear_i && !valid_i) |=> ($stable(state_q) && $stable(crc_o)));

    // R5
    reset_seed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (state_q == SEED));

    // R4
    out_known_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$isunknown(crc_o));
endmodule

bind crcx_step crcx_step_chk #(.CW(CW), .SEED(SEED)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .valid_i (valid_i),
    .state_q (r_q.crc),
    .crc_o   (crc_o)
);

// File: tb/crcx_step_bench.sv
`timescale 1ns/1ps
module crcx_step_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    bit          clr [3];
    bit          vld [3];
    bit          prb [3];
    logic [63:0] dat [3];
    bit          fired [3];
    logic [15:0] crc_a;
    logic [31:0] crc_b;
    logic [4:0]  crc_c;

    int n_vec = 0;
    int n_bad = 0;

    typedef struct {
        int          cfg;
        logic [63:0] exp;
        string       req;
    } item_t;
    item_t sb[$];
    logic [63:0] mdl [3];

    crcx_step #(.CW(16), .DW(16), .POLY(16'h1021), .SEED(16'hFFFF),
                .REFIN(1'b0), .REFOUT(1'b0)) u_crcx_step (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clr[0]), .valid_i(vld[0]),
        .data_i(dat[0][15:0]), .crc_o(crc_a));

    crcx_step #(.CW(32), .DW(8), .POLY(32'h04C11DB7), .SEED(32'hFFFFFFFF),
                .REFIN(1'b1), .REFOUT(1'b1)) u_crcx_step_b (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clr[1]), .valid_i(vld[1]),
        .data_i(dat[1][7:0]), .crc_o(crc_b));

    crcx_step #(.CW(5), .DW(11), .POLY(5'h05), .SEED(5'h1F),
                .REFIN(1'b0), .REFOUT(1'b0)) u_crcx_step_c (
        .clk_i(clk), .rst_ni(rst_n), .clear_i(clr[2]), .valid_i(vld[2]),
        .data_i(dat[2][10:0]), .crc_o(crc_c));

    function automatic int cfg_cw(int c);
        return (c == 0) ? 16 : (c == 1) ? 32 : 5;
    endfunction
    function automatic int cfg_dw(int c);
        return (c == 0) ? 16 : (c == 1) ? 8 : 11;
    endfunction
    function automatic logic [63:0] cfg_poly(int c);
        return (c == 0) ? 64'h1021 : (c == 1) ? 64'h04C11DB7 : 64'h05;
    endfunction
    function automatic logic [63:0] cfg_seed(int c);
        return (c == 0) ? 64'hFFFF : (c == 1) ? 64'hFFFFFFFF : 64'h1F;
    endfunction
    function automatic bit cfg_ref(int c);
        return (c == 1);
    endfunction

    function automatic logic [63:0] get_crc(int c);
        return (c == 0) ? {48'd0, crc_a} : (c == 1) ? {32'd0, crc_b} : {59'd0, crc_c};
    endfunction

    function automatic logic [63:0] rev_bits(logic [63:0] v, int w);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = v[w-1-i];
        return r;
    endfunction

    // Serial reference: one bit per step, order from R2/R3
    function automatic logic [63:0] model_step(logic [63:0] st, logic [63:0] d, int c);
        int          cw = cfg_cw(c);
        int          dw = cfg_dw(c);
        logic [63:0] m  = (64'd1 << cw) - 64'd1;
        for (int k = 0; k < dw; k++) begin
            int idx;
            bit fb;
            if (dw % 8 == 0) idx = 8 * (k / 8) + (cfg_ref(c) ? (k % 8) : (7 - (k % 8)));
            else             idx = dw - 1 - k;
            fb = st[cw-1] ^ d[idx];
            st = (st << 1) & m;
            if (fb) st = st ^ (cfg_poly(c) & m);
        end
        return st;
    endfunction

    function automatic logic [63:0] shown(int c, logic [63:0] st);
        return cfg_ref(c) ? rev_bits(st, cfg_cw(c)) : st;
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(int c, bit cl, bit va, logic [63:0] d, string req);
        item_t it;
        @(negedge clk);
        for (int j = 0; j < 3; j++) begin
            clr[j] = 1'b0; vld[j] = 1'b0; prb[j] = 1'b0;
        end
        if (cl)      mdl[c] = cfg_seed(c);
        else if (va) mdl[c] = model_step(mdl[c], d, c);
        it.cfg = c;
        it.exp = shown(c, mdl[c]);
        it.req = req;
        sb.push_back(it);
        clr[c] = cl;
        vld[c] = va;
        prb[c] = !cl && !va;
        dat[c] = d;
    endtask

    task automatic settle();
        @(negedge clk);
        for (int j = 0; j < 3; j++) begin
            clr[j] = 1'b0; vld[j] = 1'b0; prb[j] = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        for (int j = 0; j < 3; j++) fired[j] <= clr[j] | vld[j] | prb[j];
    end

    // Monitor: pop one expected item per fired operation
    always @(negedge clk) begin
        for (int j = 0; j < 3; j++) begin
            if (fired[j]) begin
                if (sb.size() == 0) begin
                    n_vec++; n_bad++;
                    $display("FAIL scoreboard: actual empty expected item for cfg %0d", j);
                end else begin
                    item_t it;
                    it = sb.pop_front();
                    if (it.cfg != j) begin
                        n_vec++; n_bad++;
                        $display("FAIL %s: actual cfg %0d expected cfg %0d", it.req, j, it.cfg);
                    end else begin
                        check(it.req, get_crc(j), it.exp);
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        n_vec++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        string msg;
        for (int j = 0; j < 3; j++) begin
            clr[j] = 0; vld[j] = 0; prb[j] = 0; dat[j] = '0; fired[j] = 0;
            mdl[j] = cfg_seed(j);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state on every configuration
        for (int j = 0; j < 3; j++) check("R5 reset seed", get_crc(j), shown(j, cfg_seed(j)));

        // Config A: R1 and R2 byte/bit order
        drive(0, 0, 1, 64'h3231, "R1 ascii pair");
        drive(0, 0, 1, 64'h0000, "R1 zero word");
        drive(0, 0, 1, 64'hFFFF, "R1 ones word");
        drive(0, 0, 1, 64'h0001, "R2 low byte bit0");
        drive(0, 0, 1, 64'h0080, "R2 low byte bit7");
        drive(0, 0, 1, 64'h8000, "R2 high byte bit7");
        drive(0, 0, 1, 64'h0100, "R2 high byte bit0");
        drive(0, 0, 0, 64'hDEAD, "R7 idle hold");
        drive(0, 0, 0, 64'hBEEF, "R7 idle hold data change");
        drive(0, 1, 1, 64'h1234, "R6 clear over valid");
        drive(0, 0, 1, 64'hA55A, "R1 after clear");
        settle();

        // Config B: R3/R4 reflection and the check string, R8
        msg = "123456789";
        for (int i = 0; i < 9; i++) drive(1, 0, 1, {56'd0, msg[i]}, "R3 reflected byte");
        settle();
        check("R8 check string", {32'd0, crc_b}, 64'h340BC6D9);
        drive(1, 1, 0, 64'h0, "R6 clear reflected");
        drive(1, 0, 1, 64'h01, "R4 single bit0");
        drive(1, 0, 1, 64'h80, "R4 single bit7");
        settle();

        // Config C: non-byte word, MSB first (R2)
        drive(2, 0, 1, 64'h400, "R2 odd width top bit");
        drive(2, 0, 1, 64'h001, "R2 odd width bottom bit");
        drive(2, 0, 1, 64'h5A5, "R2 odd width pattern");
        drive(2, 0, 1, 64'h7FF, "R2 odd width ones");
        drive(2, 0, 0, 64'h2AA, "R7 idle hold odd");
        settle();

        if (sb.size() != 0) begin
            n_vec++; n_bad++;
            $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule